// File: doc/BRIEF.md
# Configurable GPIO Port Controller

This block controls a 16-pin general-purpose I/O port. A small register interface (write strobe, word address, write data and a combinational read data path) sets up every pin on its own terms. Each pin can be a plain input, a software-driven output, an output owned by one of sixteen on-chip peripherals, or an analog pin. The pad drivers are always left untouched in analog mode. For every pin the block drives four pad-control signals: output enable, output value, pull-up enable and pull-down enable.

Pin levels pass through a two-stage synchronizer and are then captured into a read-only input register. Software drives outputs through an output data register, which always reads back what was written to it and never the pin level. In alternate mode, a 4-bit selector per pin picks which peripheral transmit-enable/data pair drives the pad. Open-drain drive only ever pulls the pad low: it releases the pad for a logic 1 and never drives it high.

Top module: `gpio_port`

## Requirements
- R1: After reset every configuration register and the output data register read 0. All pins are therefore inputs with push-pull type, no pull and alternate selector 0, and every pad_oe, pad_pu and pad_pd bit is 0.
- R2: A pin whose 2-bit mode field (bits 2i+1:2i of word 0) is 00 (input) has pad_oe low.
- R3: The input register (word 4) holds each pin's level, which passes through two synchronizer flops and then the register. A change on pin_in shows in the read data after the third rising edge that follows it, and not before.
- R4: Mode 01 (output) with push-pull type (bit i of word 1 is 0) drives pad_oe high, and pad_out equals bit i of the output data register (word 3).
- R5: With open-drain type (bit i of word 1 is 1), the pad is driven low (pad_oe high, pad_out 0) for a data value of 0 and released (pad_oe low) for a data value of 1. pad_out is never 1 for an open-drain pin.
- R6: Reading word 3 returns the last 16-bit value written there, whatever the pin levels. Writes to other words leave it unchanged.
- R7: The pull field (bits 2i+1:2i of word 2) encodes 00 none, 01 pull-up and 10 pull-down. Code 11 means none. The field applies in every mode except analog, and pad_pu and pad_pd are never both high.
- R8: In mode 10 (alternate), pin i uses selector s, taken from bits 4i+3:4i of word 5 for pins 0 to 7 and from bits 4(i-8)+3:4(i-8) of word 6 for pins 8 to 15. Its enable is af_tx_en[s] and its data is af_tx_data[s]. Push-pull type drives that pair directly. Open-drain type drives low only when the enable is high and the data is 0.
- R9: In mode 11 (analog), pad_oe, pad_pu and pad_pd are low, and that pin's bit of word 4 reads 0.
- R10: Writes to word 4 have no effect. The input register keeps following the pins.
- R11: A write (reg_we high at a rising edge) updates its word at that edge, and the pad outputs reflect the new word right after it. The read data is a combinational function of reg_addr. Words 0 to 6 are mode, type, pull, output data, input, alternate-low and alternate-high, and word 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| pin_in | input | 16 | Levels sensed at the pads |
| af_tx_en | input | 16 | Transmit enable from each of 16 peripherals |
| af_tx_data | input | 16 | Transmit data from each of 16 peripherals |
| pad_oe | output | 16 | Pad driver enable per pin |
| pad_out | output | 16 | Pad driven value per pin |
| pad_pu | output | 16 | Pull-up enable per pin |
| pad_pd | output | 16 | Pull-down enable per pin |

## Verification
Register writes land on the rising edge that samples reg_we, and the pad controls and read data follow with no further delay. A pin level reaches the read data only after the third rising edge, because of the two synchronizer flops and the input register. The bench drives its inputs just after each rising edge and compares everything at the falling edge against a behavioural model. In that model, writes take effect at the edge and pin levels pass through a three-entry history queue. Directed checks count edges explicitly around the pin-latency boundary and around a mode write, so both the "not yet" cycle and the "now" cycle are observed.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    typedef enum logic [1:0] {
        MODE_IN  = 2'b00,
        MODE_OUT = 2'b01,
        MODE_ALT = 2'b10,
        MODE_ANA = 2'b11
    } pin_mode_e;

    typedef enum logic [1:0] {
        PULL_NONE = 2'b00,
        PULL_UP   = 2'b01,
        PULL_DOWN = 2'b10,
        PULL_RSVD = 2'b11
    } pull_sel_e;

    localparam int REG_ADDR_W = 3;

    localparam logic [REG_ADDR_W-1:0] W_MODE   = 3'd0;
    localparam logic [REG_ADDR_W-1:0] W_TYPE   = 3'd1;
    localparam logic [REG_ADDR_W-1:0] W_PULL   = 3'd2;
    localparam logic [REG_ADDR_W-1:0] W_ODATA  = 3'd3;
    localparam logic [REG_ADDR_W-1:0] W_IDATA  = 3'd4;
    localparam logic [REG_ADDR_W-1:0] W_ALT_LO = 3'd5;
    localparam logic [REG_ADDR_W-1:0] W_ALT_HI = 3'd6;

endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_pkg::*;
#(
    parameter int NPINS  = 16,
    parameter int SEL_W  = 4,
    parameter int DATA_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we_i,
    input  logic [REG_ADDR_W-1:0]   addr_i,
    input  logic [DATA_W-1:0]       wdata_i,
    output logic [2*NPINS-1:0]      mode_o,
    output logic [NPINS-1:0]        otype_o,
    output logic [2*NPINS-1:0]      pull_o,
    output logic [NPINS-1:0]        odr_o,
    output logic [SEL_W*NPINS-1:0]  alt_o
);

    localparam int PER_WORD = DATA_W / SEL_W;
    localparam int ALT_BITS = SEL_W * NPINS;

    typedef struct packed {
        logic [2*NPINS-1:0]  mode;
        logic [NPINS-1:0]    otype;
        logic [2*NPINS-1:0]  pull;
        logic [NPINS-1:0]    odr;
        logic [ALT_BITS-1:0] alt;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we_i) begin
            case (addr_i)
                W_MODE:  cfg_d.mode  = wdata_i[2*NPINS-1:0];
                W_TYPE:  cfg_d.otype = wdata_i[NPINS-1:0];
                W_PULL:  cfg_d.pull  = wdata_i[2*NPINS-1:0];
                W_ODATA: cfg_d.odr   = wdata_i[NPINS-1:0];
                default: ;
            endcase
            for (int i = 0; i < NPINS; i++) begin
                if (addr_i == ((i < PER_WORD) ? W_ALT_LO : W_ALT_HI)) begin
                    cfg_d.alt[i*SEL_W +: SEL_W] = wdata_i[(i % PER_WORD)*SEL_W +: SEL_W];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign mode_o  = cfg_q.mode;
    assign otype_o = cfg_q.otype;
    assign pull_o  = cfg_q.pull;
    assign odr_o   = cfg_q.odr;
    assign alt_o   = cfg_q.alt;

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int NPINS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_i,
    output logic [NPINS-1:0] idr_o
);

    typedef struct packed {
        logic [NPINS-1:0] meta;
        logic [NPINS-1:0] safe;
        logic [NPINS-1:0] idr;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d      = sy_q;
        sy_d.meta = pin_i;
        sy_d.safe = sy_q.meta;
        sy_d.idr  = sy_q.safe;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sy_q <= '0;
        end else begin
            sy_q <= sy_d;
        end
    end

    assign idr_o = sy_q.idr;

endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive
    import gpio_pkg::*;
#(
    parameter int NPINS = 16,
    parameter int SEL_W = 4
) (
    input  logic [2*NPINS-1:0]      mode_i,
    input  logic [NPINS-1:0]        otype_i,
    input  logic [2*NPINS-1:0]      pull_i,
    input  logic [NPINS-1:0]        odr_i,
    input  logic [SEL_W*NPINS-1:0]  alt_i,
    input  logic [(1<<SEL_W)-1:0]   af_en_i,
    input  logic [(1<<SEL_W)-1:0]   af_data_i,
    output logic [NPINS-1:0]        oe_o,
    output logic [NPINS-1:0]        out_o,
    output logic [NPINS-1:0]        pu_o,
    output logic [NPINS-1:0]        pd_o
);

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        pin_mode_e        mode_l;
        pull_sel_e        pull_l;
        logic [SEL_W-1:0] sel_l;
        logic             en_l, dat_l, oe_l, out_l;

        assign mode_l = pin_mode_e'(mode_i[2*p +: 2]);
        assign pull_l = pull_sel_e'(pull_i[2*p +: 2]);
        assign sel_l  = alt_i[p*SEL_W +: SEL_W];

        always_comb begin
            en_l  = 1'b0;
            dat_l = 1'b0;
            case (mode_l)
                MODE_OUT: begin
                    en_l  = 1'b1;
                    dat_l = odr_i[p];
                end
                MODE_ALT: begin
                    en_l  = af_en_i[sel_l];
                    dat_l = af_data_i[sel_l];
                end
                default: ;
            endcase
            if (otype_i[p]) begin
                oe_l  = en_l & ~dat_l;
                out_l = 1'b0;
            end else begin
                oe_l  = en_l;
                out_l = en_l & dat_l;
            end
        end

        assign oe_o[p]  = oe_l;
        assign out_o[p] = out_l;
        assign pu_o[p]  = (mode_l != MODE_ANA) && (pull_l == PULL_UP);
        assign pd_o[p]  = (mode_l != MODE_ANA) && (pull_l == PULL_DOWN);
    end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int NPINS  = 16,
    parameter int SEL_W  = 4,
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_we,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    input  logic [NPINS-1:0]      pin_in,
    input  logic [(1<<SEL_W)-1:0] af_tx_en,
    input  logic [(1<<SEL_W)-1:0] af_tx_data,
    output logic [NPINS-1:0]      pad_oe,
    output logic [NPINS-1:0]      pad_out,
    output logic [NPINS-1:0]      pad_pu,
    output logic [NPINS-1:0]      pad_pd
);

    localparam int ALT_BITS = SEL_W * NPINS;

    logic [2*NPINS-1:0]  cfg_mode;
    logic [NPINS-1:0]    cfg_otype;
    logic [2*NPINS-1:0]  cfg_pull;
    logic [NPINS-1:0]    cfg_odr;
    logic [ALT_BITS-1:0] cfg_alt;
    logic [NPINS-1:0]    in_reg;
    logic [NPINS-1:0]    ana_mask;

    gpio_cfg_regs #(.NPINS(NPINS), .SEL_W(SEL_W), .DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (reg_we),
        .addr_i  (reg_addr),
        .wdata_i (reg_wdata),
        .mode_o  (cfg_mode),
        .otype_o (cfg_otype),
        .pull_o  (cfg_pull),
        .odr_o   (cfg_odr),
        .alt_o   (cfg_alt)
    );

    gpio_in_sync #(.NPINS(NPINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i (pin_in),
        .idr_o (in_reg)
    );

    gpio_pin_drive #(.NPINS(NPINS), .SEL_W(SEL_W)) u_drive (
        .mode_i    (cfg_mode),
        .otype_i   (cfg_otype),
        .pull_i    (cfg_pull),
        .odr_i     (cfg_odr),
        .alt_i     (cfg_alt),
        .af_en_i   (af_tx_en),
        .af_data_i (af_tx_data),
        .oe_o      (pad_oe),
        .out_o     (pad_out),
        .pu_o      (pad_pu),
        .pd_o      (pad_pd)
    );

    always_comb begin
        for (int i = 0; i < NPINS; i++) begin
            ana_mask[i] = (cfg_mode[2*i +: 2] == MODE_ANA);
        end
    end

    always_comb begin
        case (reg_addr)
            W_MODE:   reg_rdata = DATA_W'(cfg_mode);
            W_TYPE:   reg_rdata = DATA_W'(cfg_otype);
            W_PULL:   reg_rdata = DATA_W'(cfg_pull);
            W_ODATA:  reg_rdata = DATA_W'(cfg_odr);
            W_IDATA:  reg_rdata = DATA_W'(in_reg & ~ana_mask);
            W_ALT_LO: reg_rdata = cfg_alt[DATA_W-1:0];
            W_ALT_HI: reg_rdata = cfg_alt[ALT_BITS-1 -: DATA_W];
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
    import gpio_pkg::*;
#(
    parameter int NPINS  = 16,
    parameter int DATA_W = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  reg_we,
    input logic [REG_ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0]     reg_wdata,
    input logic [2*NPINS-1:0]    cfg_mode,
    input logic [NPINS-1:0]      cfg_otype,
    input logic [NPINS-1:0]      cfg_odr,
    input logic [NPINS-1:0]      pad_oe,
    input logic [NPINS-1:0]      pad_out,
    input logic [NPINS-1:0]      pad_pu,
    input logic [NPINS-1:0]      pad_pd
);

    logic [NPINS-1:0] is_in, is_ana, is_pp_out;

    always_comb begin
        for (int i = 0; i < NPINS; i++) begin
            is_in[i]     = (cfg_mode[2*i +: 2] == MODE_IN);
            is_ana[i]    = (cfg_mode[2*i +: 2] == MODE_ANA);
            is_pp_out[i] = (cfg_mode[2*i +: 2] == MODE_OUT) && !cfg_otype[i];
        end
    end

    assert_input_undriven_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & is_in) == '0);

    assert_pp_follows_odr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((is_pp_out & ~pad_oe) == '0) && (((pad_out ^ cfg_odr) & is_pp_out) == '0));

    assert_od_never_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out & cfg_otype) == '0);

    assert_odr_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == W_ODATA) |=> (cfg_odr == $past(reg_wdata[NPINS-1:0])));

    assert_odr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_addr == W_ODATA) |=> $stable(cfg_odr));

    assert_pull_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & pad_pd) == '0);

    assert_analog_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe | pad_pu | pad_pd) & is_ana) == '0);

endmodule

bind gpio_port gpio_port_chk #(.NPINS(NPINS), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .cfg_mode  (cfg_mode),
    .cfg_otype (cfg_otype),
    .cfg_odr   (cfg_odr),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out),
    .pad_pu    (pad_pu),
    .pad_pd    (pad_pd)
);

// File: tb/gpio_port_tb_top.sv
`timescale 1ns/1ps
module gpio_port_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] af_tx_en = '0;
    logic [15:0] af_tx_data = '0;
    logic [15:0] pad_oe, pad_out, pad_pu, pad_pd;

    int checks = 0;
    int failures = 0;
    bit run_cmp = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gpio_port dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .pin_in     (pin_in),
        .af_tx_en   (af_tx_en),
        .af_tx_data (af_tx_data),
        .pad_oe     (pad_oe),
        .pad_out    (pad_out),
        .pad_pu     (pad_pu),
        .pad_pd     (pad_pd)
    );

    // Behavioural reference model
    logic [31:0] m_mode, m_type, m_pull, m_odr, m_alo, m_ahi;
    logic [15:0] m_idr;
    logic [15:0] hist[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_type = 0; m_pull = 0; m_odr = 0; m_alo = 0; m_ahi = 0;
            m_idr = 0;
            hist.delete();
        end else begin
            if (reg_we) begin
                case (reg_addr)
                    3'd0: m_mode = reg_wdata;
                    3'd1: m_type = reg_wdata & 32'hFFFF;
                    3'd2: m_pull = reg_wdata;
                    3'd3: m_odr  = reg_wdata & 32'hFFFF;
                    3'd5: m_alo  = reg_wdata;
                    3'd6: m_ahi  = reg_wdata;
                    default: ;
                endcase
            end
            hist.push_back(pin_in);
            if (hist.size() > 3) void'(hist.pop_front());
            m_idr = (hist.size() >= 3) ? hist[hist.size()-3] : 16'h0;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string pin_tag(int md, bit od);
        if (md == 0) return "R2";
        if (md == 3) return "R9";
        if (md == 2) return "R8";
        return od ? "R5" : "R4";
    endfunction

    always @(negedge clk) begin
        if (rst_n && run_cmp) begin
            logic [15:0] e_oe, e_out, e_pu, e_pd, ana;
            logic [63:0] alw;
            logic [31:0] e_rd;
            string t_drv, t_pull, t_rd;
            alw = {m_ahi, m_alo};
            t_drv = "R11"; t_pull = "R7";
            for (int i = 0; i < 16; i++) begin
                int md, pl, sel;
                bit en, dv, od;
                md = m_mode[2*i +: 2]; pl = m_pull[2*i +: 2];
                sel = alw[4*i +: 4]; od = m_type[i];
                en = 0; dv = 0;
                if (md == 1) begin en = 1; dv = m_odr[i]; end
                if (md == 2) begin en = af_tx_en[sel]; dv = af_tx_data[sel]; end
                e_oe[i]  = od ? (en & ~dv) : en;
                e_out[i] = od ? 1'b0 : (en & dv);
                e_pu[i]  = (md != 3) && (pl == 1);
                e_pd[i]  = (md != 3) && (pl == 2);
                ana[i]   = (md == 3);
                if ((pad_oe[i] !== e_oe[i]) || (pad_out[i] !== e_out[i])) t_drv = pin_tag(md, od);
                if (md == 3 && ((pad_pu[i] !== e_pu[i]) || (pad_pd[i] !== e_pd[i]))) t_pull = "R9";
            end
            case (reg_addr)
                3'd0: begin e_rd = m_mode; t_rd = "R11"; end
                3'd1: begin e_rd = m_type; t_rd = "R11"; end
                3'd2: begin e_rd = m_pull; t_rd = "R11"; end
                3'd3: begin e_rd = m_odr;  t_rd = "R6";  end
                3'd4: begin e_rd = {16'h0, m_idr & ~ana}; t_rd = "R3"; end
                3'd5: begin e_rd = m_alo;  t_rd = "R8";  end
                3'd6: begin e_rd = m_ahi;  t_rd = "R8";  end
                default: begin e_rd = 0;   t_rd = "R11"; end
            endcase
            chk({t_drv, " pad_oe"},  {16'h0, pad_oe},  {16'h0, e_oe});
            chk({t_drv, " pad_out"}, {16'h0, pad_out}, {16'h0, e_out});
            chk({t_pull, " pad_pu"}, {16'h0, pad_pu},  {16'h0, e_pu});
            chk({t_pull, " pad_pd"}, {16'h0, pad_pd},  {16'h0, e_pd});
            chk({t_rd, " rdata"}, reg_rdata, e_rd);
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_we = 1'b0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        run_cmp = 1'b1;

        // R1: reset state of all words and pad controls
        for (int a = 0; a < 8; a++) begin
            reg_addr = 3'(a);
            @(negedge clk);
            chk("R1 reset word", reg_rdata, 32'h0);
            chk("R1 reset pads", {16'h0, pad_oe | pad_pu | pad_pd}, 32'h0);
            step();
        end

        // R10: write to input word ignored
        wr(3'd4, 32'h0000FFFF);
        reg_addr = 3'd4;
        @(negedge clk); chk("R10 idata after write", reg_rdata, 32'h0);
        step();

        // R3: three-edge latency from pin to read data
        pin_in = 16'hA5C3;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R3 latency", reg_rdata, (k >= 3) ? 32'h0000A5C3 : 32'h0);
            step();
        end

        // R6 / R11 / R4: data then mode, output visible right after mode edge
        wr(3'd3, 32'h1);
        reg_addr = 3'd3;
        @(negedge clk); chk("R6 odata readback", reg_rdata, 32'h1);
        step();
        reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h1;
        @(negedge clk); chk("R11 before write edge", {31'h0, pad_oe[0]}, 32'h0);
        step();
        reg_we = 1'b0;
        @(negedge clk);
        chk("R4 pp enable", {31'h0, pad_oe[0]}, 32'h1);
        chk("R4 pp value", {31'h0, pad_out[0]}, 32'h1);
        step();

        // R5: open drain releases on 1, drives low on 0
        wr(3'd1, 32'h1);
        @(negedge clk); chk("R5 od release", {31'h0, pad_oe[0]}, 32'h0);
        step();
        wr(3'd3, 32'h0);
        @(negedge clk);
        chk("R5 od drive low oe", {31'h0, pad_oe[0]}, 32'h1);
        chk("R5 od drive low out", {31'h0, pad_out[0]}, 32'h0);
        step();

        // R6: readback ignores pin levels
        pin_in = 16'hFFFF;
        reg_addr = 3'd3;
        @(negedge clk); chk("R6 odata not pins", reg_rdata, 32'h0);
        step();

        // R8: pin 9 routed to peripheral 5
        wr(3'd6, 32'h00000050);
        wr(3'd0, 32'h00080001);
        af_tx_en = 16'h0020; af_tx_data = 16'h0020;
        @(negedge clk);
        chk("R8 alt pp oe", {31'h0, pad_oe[9]}, 32'h1);
        chk("R8 alt pp out", {31'h0, pad_out[9]}, 32'h1);
        step();
        af_tx_data = 16'h0000;
        @(negedge clk); chk("R8 alt pp low", {31'h0, pad_out[9]}, 32'h0);
        step();
        wr(3'd1, 32'h00000201);
        af_tx_data = 16'h0020;
        @(negedge clk); chk("R8 alt od release", {31'h0, pad_oe[9]}, 32'h0);
        step();

        // R7: pull encodings, including reserved code
        wr(3'd2, 32'h000000E4);
        @(negedge clk);
        chk("R7 pull-up", {16'h0, pad_pu}, 32'h0002);
        chk("R7 pull-down", {16'h0, pad_pd}, 32'h0004);
        step();

        // R9: pin 1 analog
        wr(3'd0, 32'h0008000D);
        reg_addr = 3'd4;
        repeat (3) step();
        @(negedge clk);
        chk("R9 analog reads zero", reg_rdata, 32'h0000FFFD);
        chk("R9 analog pulls off", {30'h0, pad_pu[1], pad_pd[1]}, 32'h0);
        step();

        // Mixed traffic, compared against the model every cycle
        for (int n = 0; n < 600; n++) begin
            pin_in     = 16'($urandom);
            af_tx_en   = 16'($urandom);
            af_tx_data = 16'($urandom);
            reg_we     = ($urandom % 3) == 0;
            reg_addr   = 3'($urandom);
            reg_wdata  = $urandom;
            step();
        end
        reg_we = 1'b0;
        step();

        done = 1'b1;
        summary();
        $finish;
    end

endmodule